// File: doc/BRIEF.md
# Circular-Buffer Address Mask Unit

This unit keeps a 16-bit address mask and applies it to operand addresses that an address generator has already computed. When masking is requested for an access, the address is ANDed with a 32-bit pattern. The upper half of that pattern is all ones and the lower half is the stored mask. Clearing some low mask bits confines a post-incrementing pointer to one aligned power-of-two region. The pointer then wraps at the region boundary and serves as a circular queue for filter and convolution loops.

Software programs the mask through a 32-bit register write port. Only the low half of the written word is kept. The 32-bit read port returns the stored mask with its upper half forced to ones. The address path is combinational. A mask written in one cycle governs accesses from the next cycle onward.

Top module: `cbuf_mask_unit`

## Requirements
- R1: When `mask_wr_en` is high at a rising clock edge, bits 15:0 of `mask_wr_data` become the stored mask. Bits 31:16 of the written word have no effect on any later output.
- R2: `mask_rd_data` always shows the stored mask in bits 15:0, with bits 31:16 all ones.
- R3: While `mask_en` is high, `ea_out` equals `ea_in` ANDed with {16'hFFFF, stored mask}.
- R4: While `mask_en` is low, `ea_out` equals `ea_in` bit for bit, whatever the stored mask is.
- R5: Reset (`rst_n` low) sets the stored mask to 16'hFFFF. After reset, `mask_rd_data` reads 32'hFFFF_FFFF and an enabled access leaves its address unchanged.
- R6: An access in the same cycle as a mask write uses the old mask. The new mask applies from the next cycle onward.
- R7: A read in the same cycle as a mask write returns the old mask.
- R8: With mask 16'h00FF and enabling on, a pointer stepping by 4 from 0x1234_00F8 gives the masked addresses 0x1234_00F8, 0x1234_00FC, 0x1234_0000, 0x1234_0004. The pointer wraps inside the 256-byte region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mask_wr_en | input | 1 | Register write strobe |
| mask_wr_data | input | 32 | Register write data; only bits 15:0 are kept |
| mask_rd_data | output | 32 | Register read value {16'hFFFF, mask} |
| ea_in | input | 32 | Computed operand address |
| mask_en | input | 1 | Apply the mask to this access |
| ea_out | output | 32 | Final operand address |

## Verification
A register write can fall in the same cycle as a masked access or a read-back. The bench provokes this by driving a new mask together with an enabled address and then sampling both outputs just before the capturing edge. In that cycle, both the address and the read value must still reflect the old mask. Just after the edge they must reflect the new one. Clocked assertions compare the outputs with the previous cycle's write data to judge the same boundary.

// File: rtl/cbuf_mask_pkg.sv
package cbuf_mask_pkg;
  localparam int unsigned CBM_ADDR_W = 32;
  localparam int unsigned CBM_MASK_W = 16;

  // Build the full-width AND pattern: all ones above the stored mask bits
  function automatic logic [CBM_ADDR_W-1:0] cbm_pattern(input logic [CBM_MASK_W-1:0] m);
    logic [CBM_ADDR_W-1:0] p;
    p = '1;
    p[CBM_MASK_W-1:0] = m;
    return p;
  endfunction

  // Final address for one access
  function automatic logic [CBM_ADDR_W-1:0] cbm_apply(input logic [CBM_ADDR_W-1:0] a,
                                                      input logic [CBM_MASK_W-1:0] m,
                                                      input logic en);
    return en ? (a & cbm_pattern(m)) : a;
  endfunction
endpackage

// File: rtl/cbuf_mask_reg.sv
module cbuf_mask_reg #(
  parameter int unsigned MASK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [MASK_W-1:0] wr_low,
  output logic [MASK_W-1:0] mask_q
);
  localparam logic [MASK_W-1:0] RESET_MASK = '1;

  logic wr_fire;
  assign wr_fire = wr_en & rst_n;

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= RESET_MASK;
    else if (wr_fire) mask_q <= wr_low;
  end

  AST_WRITE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mask_q == $past(wr_low)); // R1
  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && $past(rst_n)) |=> $stable(mask_q)); // R6
endmodule

// File: rtl/cbuf_mask_readback.sv
module cbuf_mask_readback #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned MASK_W = 16
) (
  input  logic [MASK_W-1:0] mask_q,
  output logic [ADDR_W-1:0] rd_word
);
  localparam int unsigned HI_W = ADDR_W - MASK_W;
  assign rd_word = {{HI_W{1'b1}}, mask_q};
endmodule

// File: rtl/cbuf_mask_and.sv
module cbuf_mask_and #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned MASK_W = 16
) (
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [MASK_W-1:0] mask_q,
  input  logic              en,
  output logic [ADDR_W-1:0] addr_out
);
  // Per-bit gate: masked bits clear only when enabled, upper bits pass
  for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
    if (b < MASK_W) begin : g_lo
      assign addr_out[b] = addr_in[b] & (mask_q[b] | ~en);
    end else begin : g_hi
      assign addr_out[b] = addr_in[b];
    end
  end
endmodule

// File: rtl/cbuf_mask_unit.sv
module cbuf_mask_unit
  import cbuf_mask_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mask_wr_en,
  input  logic [CBM_ADDR_W-1:0] mask_wr_data,
  output logic [CBM_ADDR_W-1:0] mask_rd_data,
  input  logic [CBM_ADDR_W-1:0] ea_in,
  input  logic                  mask_en,
  output logic [CBM_ADDR_W-1:0] ea_out
);
  localparam int unsigned HI_W = CBM_ADDR_W - CBM_MASK_W;

  logic [CBM_MASK_W-1:0] mask_q;
  logic [CBM_MASK_W-1:0] wr_low;
  assign wr_low = mask_wr_data[CBM_MASK_W-1:0];

  cbuf_mask_reg #(.MASK_W(CBM_MASK_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(mask_wr_en), .wr_low(wr_low), .mask_q(mask_q));

  cbuf_mask_readback #(.ADDR_W(CBM_ADDR_W), .MASK_W(CBM_MASK_W)) u_rb (
    .mask_q(mask_q), .rd_word(mask_rd_data));

  cbuf_mask_and #(.ADDR_W(CBM_ADDR_W), .MASK_W(CBM_MASK_W)) u_and (
    .addr_in(ea_in), .mask_q(mask_q), .en(mask_en), .addr_out(ea_out));

  AST_RD_UPPER_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    mask_rd_data[CBM_ADDR_W-1:CBM_MASK_W] == {HI_W{1'b1}}); // R2
  AST_RD_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr_en |=> mask_rd_data[CBM_MASK_W-1:0] == $past(wr_low)); // R7
  AST_EN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    mask_en |-> ea_out == cbm_apply(ea_in, mask_rd_data[CBM_MASK_W-1:0], 1'b1)); // R3
  AST_NEVER_SETS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_out & ~ea_in) == '0); // R3
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_en |-> ea_out == ea_in); // R4
  AST_RESET_VALUE: assert property (@(posedge clk)
    !rst_n |=> mask_rd_data == '1); // R5
endmodule

// File: tb/cbuf_mask_unit_test.sv
module cbuf_mask_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mask_wr_en = 1'b0;
  logic [31:0] mask_wr_data = '0;
  logic [31:0] mask_rd_data;
  logic [31:0] ea_in = '0;
  logic        mask_en = 1'b0;
  logic [31:0] ea_out;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  cbuf_mask_unit uut (
    .clk(clk), .rst_n(rst_n), .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
    .mask_rd_data(mask_rd_data), .ea_in(ea_in), .mask_en(mask_en), .ea_out(ea_out));

  function automatic logic [31:0] model(input logic [31:0] a, input logic [15:0] m, input logic en);
    logic [31:0] r;
    r = a;
    if (en) for (int i = 0; i < 16; i++) if (!m[i]) r[i] = 1'b0;
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive after falling edge, settle, outputs sampled mid-cycle
  task automatic step();
    @(negedge clk); #2;
  endtask

  task automatic write_mask(input logic [31:0] d);
    @(negedge clk); mask_wr_en = 1'b1; mask_wr_data = d;
    @(negedge clk); mask_wr_en = 1'b0; #2;
  endtask

  task automatic t_reset();
    chk("R5 reset readback", mask_rd_data, 32'hFFFF_FFFF);
    @(negedge clk); mask_en = 1'b1; ea_in = 32'hDEAD_BEEF; #2;
    chk("R5 reset mask transparent", ea_out, 32'hDEAD_BEEF);
  endtask

  task automatic t_write_read();
    write_mask(32'h1234_0F0F);
    chk("R1 low half captured", mask_rd_data, 32'hFFFF_0F0F);
    write_mask(32'h0000_A5C3);
    chk("R2 upper forced to ones", mask_rd_data, 32'hFFFF_A5C3);
    write_mask(32'hFFFF_0000);
    chk("R2 zero mask readback", mask_rd_data, 32'hFFFF_0000);
  endtask

  task automatic t_and();
    logic [31:0] addrs [4] = '{32'hFFFF_FFFF, 32'h0000_0000, 32'h8001_7FFE, 32'hCAFE_BABE};
    write_mask(32'h0000_F0F0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); mask_en = 1'b1; ea_in = addrs[i]; #2;
      chk("R3 masked address", ea_out, model(addrs[i], 16'hF0F0, 1'b1));
      mask_en = 1'b0; #1;
      chk("R4 bypass", ea_out, addrs[i]);
    end
  endtask

  task automatic t_upper_ignored();
    write_mask(32'h0000_00FF);
    write_mask(32'h5A5A_00FF);
    @(negedge clk); mask_en = 1'b1; ea_in = 32'hFFFF_FFFF; #2;
    chk("R1 upper write bits no effect on address", ea_out, 32'hFFFF_00FF);
    chk("R1 upper write bits no effect on readback", mask_rd_data, 32'hFFFF_00FF);
  endtask

  task automatic t_same_cycle();
    write_mask(32'h0000_FFFF);
    @(negedge clk);
    mask_wr_en = 1'b1; mask_wr_data = 32'h0000_0F00;
    mask_en = 1'b1; ea_in = 32'h4321_FFFF; #2;
    chk("R6 same-cycle access old mask", ea_out, 32'h4321_FFFF);
    chk("R7 same-cycle read old mask", mask_rd_data, 32'hFFFF_FFFF);
    @(negedge clk); mask_wr_en = 1'b0; #2;
    chk("R6 next-cycle access new mask", ea_out, 32'h4321_0F00);
    chk("R7 next-cycle read new mask", mask_rd_data, 32'hFFFF_0F00);
  endtask

  task automatic t_wrap();
    logic [31:0] ptr;
    logic [31:0] exp [4] = '{32'h1234_00F8, 32'h1234_00FC, 32'h1234_0000, 32'h1234_0004};
    write_mask(32'h0000_00FF);
    ptr = 32'h1234_00F8;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); mask_en = 1'b1; ea_in = ptr; #2;
      chk("R8 circular wrap", ea_out, exp[i]);
      ptr = ptr + 32'd4;
    end
  endtask

  task automatic t_reset_again();
    write_mask(32'h0000_1234);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; #2;
    chk("R5 reset restores mask", mask_rd_data, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_write_read();
    t_and();
    t_upper_ignored();
    t_same_cycle();
    t_wrap();
    t_reset_again();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule